// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Overflow

This block is the multiply-accumulate stage of a 32-bit processor's execute pipe. Each cycle it may accept one operation, selected by a 4-bit code, that combines a register operand with an immediate operand. Most operations multiply the two operands and add the product into a 64-bit accumulator, which is kept as a high word and a low word. A sticky flag records any signed overflow of that accumulation. Two dual-lane multiply operations bypass the accumulator. They return one 32-bit product on a writeback port and place the other in a side result register.

The operand width, the byte-lane width and the operation set are fixed by parameters and a shared package. Every output comes straight from a register, so the effect of an operation is seen one clock after the edge that accepts it.

Top module: `mac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both accumulator words, the overflow flag, the side result register and `wb_en` are cleared to zero.
- R2: `op_sel` codes 0..9 mean, in order: word MAC signed, word MAC unsigned, byte MAC signed, byte MAC unsigned, halfword MAC signed, halfword MAC unsigned, dual-halfword MAC signed, dual-halfword MAC unsigned, dual multiply signed, dual multiply unsigned. An even code is the signed form. Codes 10..15 change no state and raise no writeback.
- R3: Word MAC (codes 0, 1) adds the full 64-bit product of the two 32-bit operands to the concatenation {acc_hi, acc_lo}. The carry out of the low word goes into the high word.
- R4: Word MAC sets the overflow flag when the old `acc_hi` bit 31 equals product bit 63 and the new `acc_hi` bit 31 differs from it. This rule also applies to the unsigned code.
- R5: Byte MAC (codes 2, 3) multiplies bits [7:0] of both operands, sign-extended for code 2 and zero-extended for code 3. It adds the 32-bit product to `acc_lo` and leaves `acc_hi` unchanged.
- R6: Halfword MAC (codes 4, 5) does the same on bits [15:0] of both operands. It also updates only `acc_lo`.
- R7: For the byte, halfword and dual-halfword MACs, overflow is set when the old `acc_lo` bit 31 equals bit 31 of the (low-lane) product and the new `acc_lo` bit 31 differs from it.
- R8: Dual-halfword MAC (codes 6, 7) adds two products to `acc_lo`: bits [15:0] times bits [15:0], and bits [31:16] times bits [31:16]. `acc_hi` is unchanged.
- R9: Dual multiply (codes 8, 9) puts the product of the low lanes in `mul_res` and the product of the high lanes on `wb_data`, with `wb_en` high for exactly one cycle. The accumulator and the flag are left unchanged.
- R10: No operation clears the overflow flag. Once set, it stays set until `acc_clr` or reset.
- R11: `acc_clr` zeroes both accumulator words and the flag. It takes priority over an operation accepted in the same cycle, and it does not affect `mul_res`.
- R12: An operation takes effect only when `op_valid` is high. Its results appear at the outputs right after the accepting rising edge, and `wb_en` is high only in the cycle that follows a dual multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_clr | input | 1 | Zero accumulator and overflow flag |
| op_valid | input | 1 | Accept the operation this cycle |
| op_sel | input | 4 | Operation code |
| reg_opnd | input | 32 | Register operand |
| imm_opnd | input | 32 | Immediate operand |
| wb_en | output | 1 | Writeback strobe (dual multiply) |
| wb_data | output | 32 | High-lane product for writeback |
| mul_res | output | 32 | Side result register (low-lane product) |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The accumulator and the flag are outputs themselves, so an error in the next-state logic shows up at the ports right after the edge that accepts the faulty operation. A wrong lane extension, a lost carry into the high word, or a narrow mode that changes `acc_hi` is therefore caught on the very next sample. A flag that is cleared when it should not be is harder to see, because it shows only after an overflow has already occurred. The bench sets the flag on purpose and then runs operations that do not overflow, to prove that it stays set.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_MAC    = 4'd0,
    OP_MACU   = 4'd1,
    OP_MACB   = 4'd2,
    OP_MACBU  = 4'd3,
    OP_MACH   = 4'd4,
    OP_MACHU  = 4'd5,
    OP_DMACH  = 4'd6,
    OP_DMACHU = 4'd7,
    OP_DMUL   = 4'd8,
    OP_DMULU  = 4'd9
  } mac_op_e;

  localparam int unsigned OP_COUNT = 10;
endpackage

// File: rtl/mac_lane_mult.sv
// One multiplier lane; operands are sign- or zero-extended by one bit.
module mac_lane_mult #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] p
);
  logic signed [W:0]     a_x;
  logic signed [W:0]     b_x;
  logic signed [2*W+1:0] full;

  always_comb begin
    a_x  = {sgn & a[W-1], a};
    b_x  = {sgn & b[W-1], b};
    full = a_x * b_x;
    p    = full[2*W-1:0];
  end
endmodule

// File: rtl/mac_next_state.sv
// Combinational next-state and overflow computation for one operation.
module mac_next_state
  import mac_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] cur_hi,
  input  logic [DW-1:0] cur_lo,
  output logic [DW-1:0] nxt_hi,
  output logic [DW-1:0] nxt_lo,
  output logic          acc_upd,
  output logic          ovf_hit,
  output logic          is_dmul,
  output logic [DW-1:0] lo_lane,
  output logic [DW-1:0] hi_lane
);
  localparam int HW = DW / 2;

  logic          sgn;
  logic [2*DW-1:0] p_word;
  logic [DW-1:0]   p_hl;
  logic [DW-1:0]   p_hh;
  logic [2*BW-1:0] p_byte;
  logic [DW-1:0]   byte_x;
  logic [2*DW-1:0] wsum;
  logic [DW-1:0]   nsum;
  logic [DW-1:0]   naddend;
  mac_op_e         op;

  assign sgn = ~op_sel[0];
  assign op  = mac_op_e'(op_sel);

  mac_lane_mult #(.W(DW)) u_word (.a(opa), .b(opb), .sgn(sgn), .p(p_word));
  mac_lane_mult #(.W(HW)) u_hl   (.a(opa[HW-1:0]), .b(opb[HW-1:0]), .sgn(sgn), .p(p_hl));
  mac_lane_mult #(.W(HW)) u_hh   (.a(opa[DW-1:HW]), .b(opb[DW-1:HW]), .sgn(sgn), .p(p_hh));
  mac_lane_mult #(.W(BW)) u_byte (.a(opa[BW-1:0]), .b(opb[BW-1:0]), .sgn(sgn), .p(p_byte));

  assign byte_x  = {{(DW-2*BW){sgn & p_byte[2*BW-1]}}, p_byte};
  assign wsum    = {cur_hi, cur_lo} + p_word;
  assign lo_lane = p_hl;
  assign hi_lane = p_hh;

  always_comb begin
    nxt_hi  = cur_hi;
    nxt_lo  = cur_lo;
    acc_upd = 1'b0;
    ovf_hit = 1'b0;
    is_dmul = 1'b0;
    naddend = p_hl;
    nsum    = cur_lo;
    case (op)
      OP_MAC, OP_MACU: begin
        acc_upd = 1'b1;
        {nxt_hi, nxt_lo} = wsum;
        ovf_hit = (cur_hi[DW-1] == p_word[2*DW-1]) && (wsum[2*DW-1] != p_word[2*DW-1]);
      end
      OP_MACB, OP_MACBU, OP_MACH, OP_MACHU, OP_DMACH, OP_DMACHU: begin
        acc_upd = 1'b1;
        naddend = (op == OP_MACB || op == OP_MACBU) ? byte_x : p_hl;
        nsum    = cur_lo + naddend;
        if (op == OP_DMACH || op == OP_DMACHU) nsum = nsum + p_hh;
        nxt_lo  = nsum;
        ovf_hit = (cur_lo[DW-1] == naddend[DW-1]) && (nsum[DW-1] != naddend[DW-1]);
      end
      OP_DMUL, OP_DMULU: is_dmul = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_clr,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] reg_opnd,
  input  logic [DW-1:0] imm_opnd,
  output logic          wb_en,
  output logic [DW-1:0] wb_data,
  output logic [DW-1:0] mul_res,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          ovf
);
  logic [DW-1:0] n_hi, n_lo, lo_lane, hi_lane;
  logic          acc_upd, ovf_hit, is_dmul;

  mac_next_state #(.DW(DW), .BW(BW)) u_next (
    .op_sel (op_sel),  .opa(reg_opnd), .opb(imm_opnd),
    .cur_hi (acc_hi),  .cur_lo(acc_lo),
    .nxt_hi (n_hi),    .nxt_lo(n_lo),
    .acc_upd(acc_upd), .ovf_hit(ovf_hit), .is_dmul(is_dmul),
    .lo_lane(lo_lane), .hi_lane(hi_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi  <= '0;
      acc_lo  <= '0;
      ovf     <= 1'b0;
      mul_res <= '0;
      wb_en   <= 1'b0;
      wb_data <= '0;
    end else begin
      wb_en <= op_valid && is_dmul;
      if (op_valid && is_dmul) begin
        mul_res <= lo_lane;
        wb_data <= hi_lane;
      end
      if (acc_clr) begin
        acc_hi <= '0;
        acc_lo <= '0;
        ovf    <= 1'b0;
      end else if (op_valid && acc_upd) begin
        acc_hi <= n_hi;
        acc_lo <= n_lo;
        if (ovf_hit) ovf <= 1'b1;
      end
    end
  end

  // R10: flag never drops without a clear
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ovf && !acc_clr |=> ovf);
  // R11: clear zeroes accumulator and flag
  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (acc_hi == '0 && acc_lo == '0 && !ovf));
  // R5 R6 R8: narrow modes keep the high word
  assert_hi_kept_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    op_valid && !acc_clr && op_sel >= 4'd2 && op_sel <= 4'd7 |=> $stable(acc_hi));
  // R9: dual multiply leaves accumulator and flag, raises writeback
  assert_dmul_wb_R9: assert property (@(posedge clk) disable iff (rst)
    op_valid && !acc_clr && (op_sel == 4'd8 || op_sel == 4'd9)
      |=> wb_en && $stable(acc_hi) && $stable(acc_lo) && $stable(ovf));
  // R2: unused codes change nothing
  assert_nop_codes_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid && !acc_clr && op_sel >= 4'd10
      |=> !wb_en && $stable(acc_hi) && $stable(acc_lo) && $stable(ovf) && $stable(mul_res));
  // R12: no strobe, no writeback and no state change
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !op_valid && !acc_clr
      |=> !wb_en && $stable(acc_hi) && $stable(acc_lo) && $stable(ovf) && $stable(mul_res));
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_clr = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] reg_opnd = '0;
  logic [31:0] imm_opnd = '0;
  logic        wb_en, ovf;
  logic [31:0] wb_data, mul_res, acc_hi, acc_lo;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mac_unit dut (.*);

  // bench model state
  logic [31:0] e_hi = '0, e_lo = '0, e_mr = '0, e_wbd = '0;
  logic        e_ovf = 1'b0, e_wb = 1'b0;

  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {4'd0, 32'h1234_5678, 32'h9ABC_DEF0}, {4'd1, 32'hFFFF_FFFF, 32'h8000_0001},
    {4'd2, 32'h0000_0080, 32'h0000_007F}, {4'd3, 32'hAAAA_AA80, 32'h5555_55FF},
    {4'd4, 32'h0000_8000, 32'h0000_8000}, {4'd5, 32'h1234_FFFF, 32'h0000_FFFF},
    {4'd6, 32'h8001_7FFF, 32'h7FFF_8001}, {4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {4'd8, 32'h8000_8000, 32'h8000_7FFF}, {4'd9, 32'hFFFF_0001, 32'hFFFF_FFFF},
    {4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF}, {4'd1, 32'h0000_0003, 32'hDEAD_BEEF},
    {4'd11, 32'h1111_1111, 32'h2222_2222}, {4'd4, 32'hCAFE_7001, 32'h0000_1234},
    {4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, {4'd6, 32'h0003_0002, 32'hFFFD_0007}
  };

  function automatic logic [31:0] ext(input logic [31:0] v, input int w, input logic s);
    logic [31:0] m;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    ext = v & m;
    if (s && w < 32 && v[w-1]) ext = ext | ~m;
  endfunction

  task automatic model(input logic [3:0] sel, input logic [31:0] r, input logic [31:0] i);
    logic s;
    logic [63:0] pa, pb, p, sum;
    logic [31:0] t1, t2, ls;
    s = ~sel[0];
    e_wb = 1'b0;
    t1 = ext(r[15:0], 16, s) * ext(i[15:0], 16, s);
    t2 = ext({16'd0, r[31:16]}, 16, s) * ext({16'd0, i[31:16]}, 16, s);
    case (sel)
      4'd0, 4'd1: begin
        pa = s ? {{32{r[31]}}, r} : {32'd0, r};
        pb = s ? {{32{i[31]}}, i} : {32'd0, i};
        p = pa * pb;
        sum = {e_hi, e_lo} + p;
        if (e_hi[31] == p[63] && sum[63] != p[63]) e_ovf = 1'b1;
        {e_hi, e_lo} = sum;
      end
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
        if (sel < 4'd4) t1 = ext({24'd0, r[7:0]}, 8, s) * ext({24'd0, i[7:0]}, 8, s);
        ls = e_lo + t1 + ((sel >= 4'd6) ? t2 : 32'd0);
        if (e_lo[31] == t1[31] && ls[31] != t1[31]) e_ovf = 1'b1;
        e_lo = ls;
      end
      4'd8, 4'd9: begin e_mr = t1; e_wbd = t2; e_wb = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " acc_hi"}, acc_hi, e_hi);
    chk({req, " acc_lo"}, acc_lo, e_lo);
    chk({req, " ovf"}, {31'd0, ovf}, {31'd0, e_ovf});
    chk({req, " mul_res"}, mul_res, e_mr);
    chk({req, " wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) chk({req, " wb_data"}, wb_data, e_wbd);
  endtask

  task automatic op(input logic [3:0] sel, input logic [31:0] r, input logic [31:0] i);
    @(negedge clk);
    op_valid = 1'b1; op_sel = sel; reg_opnd = r; imm_opnd = i;
    @(negedge clk);
    op_valid = 1'b0;
    model(sel, r, i);
  endtask

  task automatic clear();
    @(negedge clk);
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    e_hi = '0; e_lo = '0; e_ovf = 1'b0; e_wb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // table walk against the bench model (R2..R9, R12)
    for (int k = 0; k < NV; k++) begin
      op(VEC[k][67:64], VEC[k][63:32], VEC[k][31:0]);
      check_all($sformatf("R2 R12 vec%0d", k));
    end

    // R3 signed word MAC, hand values
    clear();
    op(4'd0, 32'hFFFF_FFFE, 32'd3);
    chk("R3 signed hi", acc_hi, 32'hFFFF_FFFF);
    chk("R3 signed lo", acc_lo, 32'hFFFF_FFFA);
    op(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 unsigned carry hi", acc_hi, 32'hFFFF_FFFD);
    chk("R3 unsigned lo", acc_lo, 32'hFFFF_FFFB);
    chk("R3 no ovf", {31'd0, ovf}, 32'd0);

    // R4 word overflow on second add of 2^62
    clear();
    op(4'd0, 32'h8000_0000, 32'h8000_0000);
    chk("R4 first no ovf", {31'd0, ovf}, 32'd0);
    op(4'd0, 32'h8000_0000, 32'h8000_0000);
    chk("R4 ovf set", {31'd0, ovf}, 32'd1);
    chk("R4 hi", acc_hi, 32'h8000_0000);

    // R5 byte MAC signed and unsigned
    clear();
    op(4'd2, 32'h0000_00FF, 32'h0000_0002);
    chk("R5 signed byte", acc_lo, 32'hFFFF_FFFE);
    op(4'd3, 32'h0000_00FF, 32'h0000_0002);
    chk("R5 unsigned byte", acc_lo, 32'h0000_01FC);
    chk("R5 hi kept", acc_hi, 32'd0);

    // R6 halfword signed
    clear();
    op(4'd4, 32'h0001_FFFF, 32'h0000_0003);
    chk("R6 half signed", acc_lo, 32'hFFFF_FFFD);
    chk("R6 hi kept", acc_hi, 32'd0);

    // R7 narrow overflow, R10 sticky
    clear();
    op(4'd1, 32'h7FFF_FFFF, 32'd1);
    op(4'd3, 32'd1, 32'd1);
    chk("R7 lo wrap", acc_lo, 32'h8000_0000);
    chk("R7 ovf set", {31'd0, ovf}, 32'd1);
    op(4'd3, 32'd1, 32'd1);
    chk("R10 sticky", {31'd0, ovf}, 32'd1);
    op(4'd8, 32'd1, 32'd1);
    chk("R10 sticky after dmul", {31'd0, ovf}, 32'd1);

    // R8 dual-halfword MAC
    clear();
    op(4'd6, 32'h0002_0003, 32'h0004_0005);
    chk("R8 dual sum", acc_lo, 32'h0000_0017);

    // R9 dual multiply
    op(4'd8, 32'hFFFF_0003, 32'h0002_0004);
    chk("R9 wb_en", {31'd0, wb_en}, 32'd1);
    chk("R9 signed hi lane", wb_data, 32'hFFFF_FFFE);
    chk("R9 low lane", mul_res, 32'h0000_000C);
    chk("R9 acc kept", acc_lo, 32'h0000_0017);
    @(negedge clk);
    chk("R9 wb_en one cycle", {31'd0, wb_en}, 32'd0);
    op(4'd9, 32'hFFFF_0003, 32'h0002_0004);
    chk("R9 unsigned hi lane", wb_data, 32'h0001_FFFE);

    // R2 unused code
    op(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R2 nop lo", acc_lo, 32'h0000_0017);
    chk("R2 nop wb", {31'd0, wb_en}, 32'd0);
    chk("R2 nop mul_res", mul_res, 32'h0000_000C);

    // R12 no strobe, no effect
    @(negedge clk);
    op_sel = 4'd0; reg_opnd = 32'd5; imm_opnd = 32'd5;
    @(negedge clk);
    chk("R12 idle lo", acc_lo, 32'h0000_0017);

    // R11 clear wins over a same-cycle op; mul_res untouched
    @(negedge clk);
    acc_clr = 1'b1; op_valid = 1'b1; op_sel = 4'd0; reg_opnd = 32'd9; imm_opnd = 32'd9;
    @(negedge clk);
    acc_clr = 1'b0; op_valid = 1'b0;
    chk("R11 lo", acc_lo, 32'd0);
    chk("R11 hi", acc_hi, 32'd0);
    chk("R11 mul_res kept", mul_res, 32'h0000_000C);

    // R1 reset mid-run
    op(4'd0, 32'd7, 32'd7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset lo", acc_lo, 32'd0);
    chk("R1 reset mul_res", mul_res, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule